// File: doc/BRIEF.md
# Processor Status and Banked Register File

This block keeps a processor's status word and its floating-point control word. It also keeps two sets of eight 32-bit integer registers and two sets of sixteen 32-bit floating-point registers. Only one set of each kind is visible at a time. Which integer set is visible follows two privilege bits of the status word. Which floating-point set is visible follows one bit of the control word. A single write to either word that changes the selecting condition exchanges the visible set and the hidden set.

The four condition flags (T, S, M, Q) are held as separate bits. Execution logic can update them one at a time through a flag port. Reading the status word merges the live flags into their positions. A three-bit mode output tells the instruction side the current privilege and floating-point format. A one-cycle pulse follows every status write so that interrupt logic can check its mask again.

All ports are plain register-style control and data pins. A write takes effect at the next rising clock edge. No port applies back-pressure, so every write enable is accepted in the cycle it is high. Reads are combinational from the stored state.

Top module: `ctl_state_bank`

## Requirements
- R1: After reset, the status read gives 0x700000F0 and the control read gives 0x00040001. The mode output is 3'b100, the pulse is low, and every register in all four sets reads zero.
- R2: A status write stores its data ANDed with 0x700083F3. A control write stores its data ANDed with 0x003FFFFF. Both are visible on the read ports in the cycle after the write.
- R3: A status write loads T, S, Q and M from data bits 0, 1, 8 and 9. The flag port updates single flags: enable and data bit 0 is T, bit 1 is S, bit 2 is M and bit 3 is Q. The status read always shows T at bit 0, S at bit 1, Q at bit 8 and M at bit 9.
- R4: When a status write and a flag-port update fall in the same cycle, the flags take the values carried by the status write.
- R5: The visible integer set is exchanged with the hidden one exactly when the value of (bit 30 AND bit 29) of the stored status word changes on a status write. The contents of both sets are kept.
- R6: The visible floating-point set is exchanged with the hidden one exactly when bit 21 of the stored control word changes on a control write. The contents of both sets are kept.
- R7: A register write in the same cycle as a write that exchanges sets lands in the set that was visible before that cycle.
- R8: The mode output equals {status bit 30, control bit 20, control bit 19}, taken from the stored values. It is updated in the cycle after a status or control write.
- R9: The pulse output is high for exactly the one cycle after each status write, even when the value written is unchanged. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write data |
| sr_rdata | output | 32 | Status word with live flags merged |
| flag_we | input | 4 | Per-flag update enable {Q,M,S,T} |
| flag_wdata | input | 4 | Per-flag update value {Q,M,S,T} |
| fpscr_we | input | 1 | Floating-point control write enable |
| fpscr_wdata | input | 32 | Floating-point control write data |
| fpscr_rdata | output | 32 | Stored floating-point control word |
| gpr_we | input | 1 | Visible integer register write enable |
| gpr_waddr | input | 3 | Integer write index |
| gpr_wdata | input | 32 | Integer write data |
| gpr_raddr | input | 3 | Integer read index |
| gpr_rdata | output | 32 | Visible integer register contents |
| fpr_we | input | 1 | Visible floating-point register write enable |
| fpr_waddr | input | 4 | Floating-point write index |
| fpr_wdata | input | 32 | Floating-point write data |
| fpr_raddr | input | 4 | Floating-point read index |
| fpr_rdata | output | 32 | Visible floating-point register contents |
| exec_mode | output | 3 | {privilege, transfer size, precision} |
| mask_chg | output | 1 | One-cycle pulse after a status write |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a status write and a flag-port update. The bench drives both with opposite flag values and expects the status write's flags on the next read. The second pair is a register write and a status or control write that exchanges sets. The bench sweeps every old/new combination of the selecting bits, writes a register in that same cycle, and then reads back the whole visible set. It expects the new write only in the set that was visible before the exchange.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] SR_WMASK   = 32'h7000_83F3;
  localparam logic [XLEN-1:0] FP_WMASK   = 32'h003F_FFFF;
  localparam logic [XLEN-1:0] SR_RSTVAL  = 32'h7000_00F0;
  localparam logic [XLEN-1:0] FP_RSTVAL  = 32'h0004_0001;
  localparam int SR_T  = 0;
  localparam int SR_S  = 1;
  localparam int SR_Q  = 8;
  localparam int SR_M  = 9;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;
  localparam int FP_PR = 19;
  localparam int FP_SZ = 20;
  localparam int FP_FR = 21;
  localparam logic [XLEN-1:0] FLAG_POS = (32'h1 << SR_T) | (32'h1 << SR_S) |
                                         (32'h1 << SR_Q) | (32'h1 << SR_M);

  typedef struct packed {
    logic q;
    logic m;
    logic s;
    logic t;
  } flags_t;
endpackage

// File: rtl/csb_flags.sv
module csb_flags
  import csb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  flags_t     load_val,
  input  logic [3:0] upd_we,
  input  logic [3:0] upd_val,
  output flags_t     flags
);
  flags_t rst_flags;
  assign rst_flags = '{q: SR_RSTVAL[SR_Q], m: SR_RSTVAL[SR_M],
                       s: SR_RSTVAL[SR_S], t: SR_RSTVAL[SR_T]};

  // a whole-word load outranks single-flag updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= rst_flags;
    end else if (load) begin
      flags <= load_val;
    end else begin
      if (upd_we[0]) flags.t <= upd_val[0];
      if (upd_we[1]) flags.s <= upd_val[1];
      if (upd_we[2]) flags.m <= upd_val[2];
      if (upd_we[3]) flags.q <= upd_val[3];
    end
  end
endmodule

// File: rtl/csb_bank.sv
module csb_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [1:0][W-1:0] bank_rd;

  for (genvar b = 0; b < 2; b++) begin : g_set
    logic [W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we && (sel == b[0])) begin
        cells[waddr] <= wdata;
      end
    end
    assign bank_rd[b] = cells[raddr];
  end

  assign rdata = bank_rd[sel];
endmodule

// File: rtl/ctl_state_bank.sv
module ctl_state_bank
  import csb_pkg::*;
#(
  parameter int NGPR = 8,
  parameter int NFPR = 16,
  localparam int GAW = $clog2(NGPR),
  localparam int FAW = $clog2(NFPR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_we,
  input  logic [31:0]     sr_wdata,
  output logic [31:0]     sr_rdata,
  input  logic [3:0]      flag_we,
  input  logic [3:0]      flag_wdata,
  input  logic            fpscr_we,
  input  logic [31:0]     fpscr_wdata,
  output logic [31:0]     fpscr_rdata,
  input  logic            gpr_we,
  input  logic [GAW-1:0]  gpr_waddr,
  input  logic [31:0]     gpr_wdata,
  input  logic [GAW-1:0]  gpr_raddr,
  output logic [31:0]     gpr_rdata,
  input  logic            fpr_we,
  input  logic [FAW-1:0]  fpr_waddr,
  input  logic [31:0]     fpr_wdata,
  input  logic [FAW-1:0]  fpr_raddr,
  output logic [31:0]     fpr_rdata,
  output logic [2:0]      exec_mode,
  output logic            mask_chg
);
  logic [31:0] sr_word;
  logic [31:0] fp_word;
  logic [31:0] sr_next;
  logic [31:0] fp_next;
  flags_t      flags;
  flags_t      wr_flags;
  logic        int_sel;
  logic        fp_sel;

  assign sr_next = sr_wdata & SR_WMASK;
  assign fp_next = fpscr_wdata & FP_WMASK;
  assign wr_flags = '{q: sr_wdata[SR_Q], m: sr_wdata[SR_M],
                      s: sr_wdata[SR_S], t: sr_wdata[SR_T]};

  // set selection follows stored words; a changed condition flips the pointer
  assign int_sel = sr_word[SR_MD] & sr_word[SR_RB];
  assign fp_sel  = fp_word[FP_FR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_word   <= SR_RSTVAL;
      fp_word   <= FP_RSTVAL;
      exec_mode <= {SR_RSTVAL[SR_MD], FP_RSTVAL[FP_SZ], FP_RSTVAL[FP_PR]};
      mask_chg  <= 1'b0;
    end else begin
      if (sr_we) sr_word <= sr_next;
      if (fpscr_we) fp_word <= fp_next;
      if (sr_we || fpscr_we) begin
        exec_mode <= {(sr_we ? sr_next[SR_MD] : sr_word[SR_MD]),
                      (fpscr_we ? fp_next[FP_SZ] : fp_word[FP_SZ]),
                      (fpscr_we ? fp_next[FP_PR] : fp_word[FP_PR])};
      end
      mask_chg <= sr_we;
    end
  end

  csb_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sr_we),
    .load_val (wr_flags),
    .upd_we   (flag_we),
    .upd_val  (flag_wdata),
    .flags    (flags)
  );

  always_comb begin
    sr_rdata = sr_word & ~FLAG_POS;
    sr_rdata[SR_T] = flags.t;
    sr_rdata[SR_S] = flags.s;
    sr_rdata[SR_Q] = flags.q;
    sr_rdata[SR_M] = flags.m;
  end

  assign fpscr_rdata = fp_word;

  csb_bank #(.W(XLEN), .DEPTH(NGPR)) u_gpr (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (int_sel),
    .we    (gpr_we),
    .waddr (gpr_waddr),
    .wdata (gpr_wdata),
    .raddr (gpr_raddr),
    .rdata (gpr_rdata)
  );

  csb_bank #(.W(XLEN), .DEPTH(NFPR)) u_fpr (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (fp_sel),
    .we    (fpr_we),
    .waddr (fpr_waddr),
    .wdata (fpr_wdata),
    .raddr (fpr_raddr),
    .rdata (fpr_rdata)
  );
endmodule

// File: rtl/csb_chk.sv
module csb_chk #(
  parameter int NGPR = 8,
  parameter int NFPR = 16,
  localparam int GAW = $clog2(NGPR),
  localparam int FAW = $clog2(NFPR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sr_we,
  input logic [31:0]     sr_wdata,
  input logic [31:0]     sr_rdata,
  input logic [3:0]      flag_we,
  input logic [3:0]      flag_wdata,
  input logic            fpscr_we,
  input logic [31:0]     fpscr_wdata,
  input logic [31:0]     fpscr_rdata,
  input logic            gpr_we,
  input logic [GAW-1:0]  gpr_raddr,
  input logic [31:0]     gpr_rdata,
  input logic            fpr_we,
  input logic [FAW-1:0]  fpr_raddr,
  input logic [31:0]     fpr_rdata,
  input logic [2:0]      exec_mode,
  input logic            mask_chg
);
  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> mask_chg); // R9
  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> !mask_chg); // R9
  AST_SR_UNWRITABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> ((sr_rdata & ~32'h7000_83F3) == 32'h0)); // R2
  AST_FP_STORED_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    fpscr_we |=> (fpscr_rdata == ($past(fpscr_wdata) & 32'h003F_FFFF))); // R2
  AST_WORD_BEATS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && flag_we != 4'h0) |=>
      (sr_rdata[0] == $past(sr_wdata[0]) && sr_rdata[1] == $past(sr_wdata[1]) &&
       sr_rdata[8] == $past(sr_wdata[8]) && sr_rdata[9] == $past(sr_wdata[9]))); // R4
  AST_GPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_we && !gpr_we) |=> (gpr_raddr != $past(gpr_raddr)) || $stable(gpr_rdata)); // R5
  AST_FPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fpscr_we && !fpr_we) |=> (fpr_raddr != $past(fpr_raddr)) || $stable(fpr_rdata)); // R6
  AST_MODE_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> exec_mode[2] == sr_rdata[30]); // R8
  AST_MODE_FP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> exec_mode[1:0] == {fpscr_rdata[20], fpscr_rdata[19]}); // R8
endmodule

bind ctl_state_bank csb_chk #(.NGPR(NGPR), .NFPR(NFPR)) u_chk (.*);

// File: tb/sim_ctl_state_bank.sv
module sim_ctl_state_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_we = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic [3:0]  flag_we = '0;
  logic [3:0]  flag_wdata = '0;
  logic        fpscr_we = 1'b0;
  logic [31:0] fpscr_wdata = '0;
  logic [31:0] fpscr_rdata;
  logic        gpr_we = 1'b0;
  logic [2:0]  gpr_waddr = '0;
  logic [31:0] gpr_wdata = '0;
  logic [2:0]  gpr_raddr = '0;
  logic [31:0] gpr_rdata;
  logic        fpr_we = 1'b0;
  logic [3:0]  fpr_waddr = '0;
  logic [31:0] fpr_wdata = '0;
  logic [3:0]  fpr_raddr = '0;
  logic [31:0] fpr_rdata;
  logic [2:0]  exec_mode;
  logic        mask_chg;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [31:0] m_sr;
  logic [31:0] m_fp;
  logic        m_t, m_s, m_m, m_q;
  logic        m_pulse;
  logic [31:0] m_ib [2][8];
  logic [31:0] m_fb [2][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_state_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .fpscr_we(fpscr_we), .fpscr_wdata(fpscr_wdata), .fpscr_rdata(fpscr_rdata),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
    .fpr_we(fpr_we), .fpr_waddr(fpr_waddr), .fpr_wdata(fpr_wdata),
    .fpr_raddr(fpr_raddr), .fpr_rdata(fpr_rdata),
    .exec_mode(exec_mode), .mask_chg(mask_chg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_sr();
    return (m_sr & ~32'h0000_0303) | {22'b0, m_m, m_q, 6'b0, m_s, m_t};
  endfunction

  task automatic model_reset();
    m_sr = 32'h7000_00F0;
    m_fp = 32'h0004_0001;
    m_t = 1'b0; m_s = 1'b0; m_m = 1'b0; m_q = 1'b0;
    m_pulse = 1'b0;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 8; i++) m_ib[b][i] = '0;
      for (int i = 0; i < 16; i++) m_fb[b][i] = '0;
    end
  endtask

  // apply driven inputs for one edge, then update the reference
  task automatic tick();
    logic isel, fsel;
    @(posedge clk);
    isel = m_sr[30] & m_sr[29];
    fsel = m_fp[21];
    if (gpr_we) m_ib[isel][gpr_waddr] = gpr_wdata;   // R7: pre-exchange set
    if (fpr_we) m_fb[fsel][fpr_waddr] = fpr_wdata;
    if (sr_we) begin
      m_sr = sr_wdata & 32'h7000_83F3;
      m_t = sr_wdata[0]; m_s = sr_wdata[1]; m_q = sr_wdata[8]; m_m = sr_wdata[9];
    end else begin
      if (flag_we[0]) m_t = flag_wdata[0];
      if (flag_we[1]) m_s = flag_wdata[1];
      if (flag_we[2]) m_m = flag_wdata[2];
      if (flag_we[3]) m_q = flag_wdata[3];
    end
    if (fpscr_we) m_fp = fpscr_wdata & 32'h003F_FFFF;
    m_pulse = sr_we;
    @(negedge clk);
    sr_we = 1'b0; flag_we = '0; fpscr_we = 1'b0; gpr_we = 1'b0; fpr_we = 1'b0;
  endtask

  task automatic check_words(input string tag);
    check({tag, " R2/R3 sr"}, sr_rdata, exp_sr());
    check({tag, " R2 fpscr"}, fpscr_rdata, m_fp);
    check({tag, " R8 mode"}, {29'b0, exec_mode}, {29'b0, m_sr[30], m_fp[20], m_fp[19]});
    check({tag, " R9 pulse"}, {31'b0, mask_chg}, {31'b0, m_pulse});
  endtask

  task automatic check_banks(input string tag);
    logic isel, fsel;
    isel = m_sr[30] & m_sr[29];
    fsel = m_fp[21];
    for (int i = 0; i < 8; i++) begin
      gpr_raddr = i[2:0];
      #1;
      check({tag, " R5 gpr"}, gpr_rdata, m_ib[isel][i]);
    end
    for (int i = 0; i < 16; i++) begin
      fpr_raddr = i[3:0];
      #1;
      check({tag, " R6 fpr"}, fpr_rdata, m_fb[fsel][i]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_words("R1 reset");
    check_banks("R1 reset");

    // fill every set with distinct contents
    for (int b = 0; b < 2; b++) begin
      sr_we = 1'b1; sr_wdata = b[0] ? 32'h6000_00F0 : 32'h0000_00F0; tick();
      fpscr_we = 1'b1; fpscr_wdata = b[0] ? 32'h0020_0000 : 32'h0; tick();
      for (int i = 0; i < 16; i++) begin
        fpr_we = 1'b1; fpr_waddr = i[3:0]; fpr_wdata = 32'hF000_0000 | (b << 8) | i;
        if (i < 8) begin
          gpr_we = 1'b1; gpr_waddr = i[2:0]; gpr_wdata = 32'hA000_0000 | (b << 8) | i;
        end
        tick();
      end
    end
    check_banks("fill");

    // R5 R7: every old/new pair of the privilege bits, register write in the same cycle
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        sr_we = 1'b1; sr_wdata = {1'b0, o[1:0], 29'h0000_0301};
        tick();
        sr_we = 1'b1; sr_wdata = {1'b0, n[1:0], 29'h1000_8072} ^ {22'b0, n[1:0], 8'h0};
        gpr_we = 1'b1; gpr_waddr = 3'((o * 4 + n) % 8); gpr_wdata = 32'h5500_0000 + (o * 16 + n);
        tick();
        check_words("R5 R7 sweep");
        check_banks("R5 R7 sweep");
      end
    end

    // R6 R7: control word exchange sweep with same-cycle register write
    for (int o = 0; o < 2; o++) begin
      for (int n = 0; n < 2; n++) begin
        for (int z = 0; z < 4; z++) begin
          fpscr_we = 1'b1; fpscr_wdata = {10'h0, o[0], 21'h0};
          tick();
          fpscr_we = 1'b1; fpscr_wdata = {10'h3FF, n[0], z[1:0], 19'h2_5A5A};
          fpr_we = 1'b1; fpr_waddr = 4'(o * 8 + n * 4 + z); fpr_wdata = 32'h7700_0000 + (o * 64 + n * 8 + z);
          tick();
          check_words("R6 R8 sweep");
          check_banks("R6 R7 sweep");
        end
      end
    end

    // R3: every flag enable against every flag value
    for (int w = 0; w < 16; w++) begin
      for (int v = 0; v < 16; v++) begin
        flag_we = w[3:0]; flag_wdata = v[3:0];
        tick();
        check_words("R3 flags");
      end
    end

    // R4: word write and flag updates in one cycle, with opposite values
    for (int v = 0; v < 16; v++) begin
      sr_we = 1'b1;
      sr_wdata = 32'h4000_00F0 | {22'b0, v[2], v[3], 6'b0, v[1], v[0]};
      flag_we = 4'hF; flag_wdata = ~v[3:0];
      tick();
      check_words("R4 priority");
    end

    // R2: all-ones writes expose the writable masks
    sr_we = 1'b1; sr_wdata = 32'hFFFF_FFFF;
    fpscr_we = 1'b1; fpscr_wdata = 32'hFFFF_FFFF;
    tick();
    check_words("R2 masks");
    check_banks("R2 masks");
    // R9: identical rewrite still pulses, then idle cycle is quiet
    sr_we = 1'b1; sr_wdata = 32'hFFFF_FFFF;
    tick();
    check_words("R9 rewrite");
    tick();
    check_words("R9 idle");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule